// File: doc/BRIEF.md
# Direct-Mapped Write-Back Byte Cache

This block is a small data cache placed between a byte-wide load/store port and a backing memory. The backing memory is read and written one whole block at a time. The cache is direct-mapped. Every byte address is cut into a block offset (the low bits), a line index (the next bits) and a tag (the remaining upper bits). Each line stores a valid flag, a dirty flag, a tag and one block of data.

A hit is served without touching memory. A miss refills the line with the requested block. If the line being replaced holds modified data, that data is first copied back to memory. Stores follow a write-back, write-allocate policy: a store changes only the cached byte and marks the line dirty. A store that misses first brings the whole block in, then merges its byte. Two counters record how many accesses hit and how many missed.

The requester raises `cpu_req` together with its command and holds all of them steady until `cpu_done` pulses. The memory side keeps `mem_req` and its command steady until `mem_ready` is strobed for one cycle. On a read, the returned block must be valid on `mem_rblock` during that strobe cycle.

Top module: `wb_byte_cache`

## Requirements
- R1: The address is split as follows. The low log2(BLOCK_BYTES) bits are the byte offset. The next log2(NUM_LINES) bits are the line index. The remaining upper bits are the tag. The block address on the memory port is the address with the offset dropped, so the line used is the block number modulo NUM_LINES. Within a block, byte k sits at bits [8k+7:8k].
- R2: While reset is high, every line is made invalid and clean and both counters are cleared. After reset, `cpu_done` and `mem_req` are low.
- R3: An access hits when its line is valid and the stored tag equals the address tag. A hit makes no memory request. It raises `cpu_done` in the cycle after the request is accepted and adds one to `hit_count`. A load hit returns the addressed byte on `cpu_rdata`.
- R4: A store hit writes only the cached byte and sets the line's dirty flag. Any number of stores to a resident line cause no memory write until the line is evicted.
- R5: A miss on a line that is invalid or clean makes exactly one block read, at the requested block address, and no write. It then installs the block with the new tag and adds one to `miss_count`. `cpu_done` follows after the read is strobed ready.
- R6: A miss on a line that is valid and dirty first writes the old block, at block address {old tag, index}, and only then reads the new block. This means a load miss can cause a memory write.
- R7: A store miss fetches the block, replaces the addressed byte and leaves the line dirty. A later eviction writes back the merged block, and its untouched bytes keep their fetched values.
- R8: A refill caused by a load leaves the line clean. Evicting such a line later causes no memory write.
- R9: `cpu_done` is high for one cycle per access. While `mem_req` waits for `mem_ready`, `mem_req`, `mem_we` and `mem_baddr` stay unchanged.
- R10: Start from memory bytes 78,29,120,123,71,150,162,173,18,21,33,28,19,200,210,225 and an empty cache. The sequence load 1, load 8, store 18 to 4, store 29 to 13, load 9 ends with 1 hit and 4 misses, and memory byte 4 then holds 18. Continuing with load 3, store 29 to 2, load 11 gives 2 hits and 6 misses, and memory byte 2 then holds 29.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Access request, held until done |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 8 | Store byte |
| cpu_rdata | output | 8 | Load result, valid with done |
| cpu_done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory block request |
| mem_we | output | 1 | 1 = block write-back, 0 = block fetch |
| mem_baddr | output | ADDR_W-log2(BLOCK_BYTES) | Block address |
| mem_wblock | output | 8*BLOCK_BYTES | Block written back |
| mem_rblock | input | 8*BLOCK_BYTES | Block returned, valid with ready |
| mem_ready | input | 1 | One-cycle completion strobe from memory |
| hit_count | output | CNT_W | Number of hits |
| miss_count | output | CNT_W | Number of misses |

## Verification
The bench uses the default geometry: 4-bit addresses, 2-byte blocks and 4 lines, so 1 tag bit. With these values the whole 16-byte memory fits in the bench's model, and the full worked sequence can be replayed with known byte values and known hit and miss totals. The single tag bit means two blocks compete for every line, so clean evictions, dirty evictions, store-miss allocation and store bursts can all be reached within a handful of accesses. The memory model answers after a fixed delay of several cycles, which keeps the port-holding rule under test.

// File: rtl/cache_pkg.sv
package cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WBACK = 2'd1,
        ST_FILL  = 2'd2,
        ST_DONE  = 2'd3
    } miss_state_t;

    typedef struct packed {
        logic valid;
        logic dirty;
    } line_flags_t;

    // First step after a miss: copy the victim back only if it is modified.
    function automatic miss_state_t miss_first_step(input line_flags_t victim);
        return (victim.valid && victim.dirty) ? ST_WBACK : ST_FILL;
    endfunction

endpackage

// File: rtl/cache_addr_split.sv
module cache_addr_split #(
    parameter int ADDR_W = 4,
    parameter int OFF_W  = 1,
    parameter int IDX_W  = 2
) (
    input  logic [ADDR_W-1:0]              addr,
    output logic [ADDR_W-OFF_W-IDX_W-1:0]  tag,
    output logic [IDX_W-1:0]               idx,
    output logic [OFF_W-1:0]               off
);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    assign off = addr[OFF_W-1:0];
    assign idx = addr[OFF_W +: IDX_W];
    assign tag = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/cache_line_store.sv
module cache_line_store
    import cache_pkg::*;
#(
    parameter int NUM_LINES = 4,
    parameter int IDX_W     = 2,
    parameter int TAG_W     = 1,
    parameter int BLK_W     = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  rd_idx,
    output line_flags_t       rd_flags,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [BLK_W-1:0]  rd_block,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [BLK_W-1:0]  wr_block,
    input  logic              wr_dirty
);
    line_flags_t        flags_q [NUM_LINES];
    logic [TAG_W-1:0]   tag_q   [NUM_LINES];
    logic [BLK_W-1:0]   data_q  [NUM_LINES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (rst) begin
                flags_q[i] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(i)) begin
                flags_q[i] <= '{valid: 1'b1, dirty: wr_dirty};
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_LINES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) begin
                tag_q[i]  <= wr_tag;
                data_q[i] <= wr_block;
            end
        end
    end

    assign rd_flags = flags_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_block = data_q[rd_idx];

    // R5
    line_valid_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> flags_q[$past(wr_idx)].valid);
endmodule

// File: rtl/cache_miss_fsm.sv
module cache_miss_fsm
    import cache_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         cpu_req,
    input  logic         hit,
    input  line_flags_t  victim,
    input  logic         mem_ready,
    output miss_state_t  state,
    output logic         hit_evt,
    output logic         miss_evt,
    output logic         fill_cmt,
    output logic         done,
    output logic         mem_req,
    output logic         mem_we
);
    miss_state_t state_q, state_d;

    always_comb begin
        state_d  = state_q;
        hit_evt  = 1'b0;
        miss_evt = 1'b0;
        fill_cmt = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (cpu_req) begin
                    if (hit) begin
                        hit_evt = 1'b1;
                        state_d = ST_DONE;
                    end else begin
                        miss_evt = 1'b1;
                        state_d  = miss_first_step(victim);
                    end
                end
            end
            ST_WBACK: if (mem_ready) state_d = ST_FILL;
            ST_FILL: begin
                if (mem_ready) begin
                    fill_cmt = 1'b1;
                    state_d  = ST_DONE;
                end
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    assign state   = state_q;
    assign done    = (state_q == ST_DONE);
    assign mem_req = (state_q == ST_WBACK) || (state_q == ST_FILL);
    assign mem_we  = (state_q == ST_WBACK);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/wb_byte_cache.sv
module wb_byte_cache
    import cache_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int BLOCK_BYTES = 2,
    parameter int NUM_LINES   = 4,
    parameter int CNT_W       = 16
) (
    input  logic                                      clk,
    input  logic                                      rst,
    input  logic                                      cpu_req,
    input  logic                                      cpu_we,
    input  logic [ADDR_W-1:0]                         cpu_addr,
    input  logic [7:0]                                cpu_wdata,
    output logic [7:0]                                cpu_rdata,
    output logic                                      cpu_done,
    output logic                                      mem_req,
    output logic                                      mem_we,
    output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0]     mem_baddr,
    output logic [8*BLOCK_BYTES-1:0]                  mem_wblock,
    input  logic [8*BLOCK_BYTES-1:0]                  mem_rblock,
    input  logic                                      mem_ready,
    output logic [CNT_W-1:0]                          hit_count,
    output logic [CNT_W-1:0]                          miss_count
);
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int IDX_W   = $clog2(NUM_LINES);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
    localparam int BLK_W   = 8 * BLOCK_BYTES;

    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [OFF_W-1:0]  a_off;

    line_flags_t       line_flags;
    logic [TAG_W-1:0]  line_tag;
    logic [BLK_W-1:0]  line_block;

    miss_state_t       state;
    logic              hit, hit_evt, miss_evt, fill_cmt;
    logic              wr_en;
    logic [BLK_W-1:0]  merge_src, merged;
    logic [7:0]        rdata_q;
    logic [CNT_W-1:0]  hits_q, misses_q;

    cache_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
        .addr (cpu_addr),
        .tag  (a_tag),
        .idx  (a_idx),
        .off  (a_off)
    );

    cache_line_store #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_lines (
        .clk      (clk),
        .rst      (rst),
        .rd_idx   (a_idx),
        .rd_flags (line_flags),
        .rd_tag   (line_tag),
        .rd_block (line_block),
        .wr_en    (wr_en),
        .wr_idx   (a_idx),
        .wr_tag   (a_tag),
        .wr_block (merged),
        .wr_dirty (cpu_we)
    );

    assign hit = line_flags.valid && (line_tag == a_tag);

    cache_miss_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cpu_req   (cpu_req),
        .hit       (hit),
        .victim    (line_flags),
        .mem_ready (mem_ready),
        .state     (state),
        .hit_evt   (hit_evt),
        .miss_evt  (miss_evt),
        .fill_cmt  (fill_cmt),
        .done      (cpu_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we)
    );

    // Byte merge: the refill block or the resident block, with the store byte laid in.
    assign merge_src = fill_cmt ? mem_rblock : line_block;

    for (genvar b = 0; b < BLOCK_BYTES; b++) begin : g_merge
        assign merged[8*b +: 8] = (cpu_we && a_off == OFF_W'(b)) ? cpu_wdata : merge_src[8*b +: 8];
    end

    assign wr_en = (hit_evt && cpu_we) || fill_cmt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (hit_evt || fill_cmt) begin
            rdata_q <= merged[{a_off, 3'b000} +: 8];
        end
    end
    assign cpu_rdata = rdata_q;

    assign mem_baddr  = (state == ST_WBACK) ? {line_tag, a_idx} : {a_tag, a_idx};
    assign mem_wblock = line_block;

    always_ff @(posedge clk) begin
        if (rst) begin
            hits_q   <= '0;
            misses_q <= '0;
        end else begin
            if (hit_evt)  hits_q   <= hits_q + CNT_W'(1);
            if (miss_evt) misses_q <= misses_q + CNT_W'(1);
        end
    end
    assign hit_count  = hits_q;
    assign miss_count = misses_q;

    // R6
    wb_then_fill_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ready) |=>
            (mem_req && !mem_we && mem_baddr == {$past(a_tag), $past(a_idx)}));

    // R9
    mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_we) && $stable(mem_baddr)));

    // R3
    hit_step_chk: assert property (@(posedge clk) disable iff (rst)
        (hit_count != $past(hit_count)) |-> (hit_count == $past(hit_count) + CNT_W'(1)));

    // R5
    miss_step_chk: assert property (@(posedge clk) disable iff (rst)
        (miss_count != $past(miss_count)) |-> (miss_count == $past(miss_count) + CNT_W'(1)));
endmodule

// File: tb/sim_wb_byte_cache.sv
module sim_wb_byte_cache;
    localparam int ADDR_W = 4;
    localparam int BB     = 2;
    localparam int NL     = 4;
    localparam int CW     = 16;
    localparam int LAT    = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [3:0]  cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_done;
    logic        mem_req, mem_we;
    logic [2:0]  mem_baddr;
    logic [15:0] mem_wblock;
    logic [15:0] mem_rblock = '0;
    logic        mem_ready = 1'b0;
    logic [CW-1:0] hit_count, miss_count;

    int total = 0, fails = 0;
    int wr_ops = 0, rd_ops = 0;
    int last_wr_baddr = -1, last_rd_baddr = -1;
    logic [7:0] mem_model [16];
    bit finished = 0;

    always #10 clk = ~clk;

    wb_byte_cache #(.ADDR_W(ADDR_W), .BLOCK_BYTES(BB), .NUM_LINES(NL), .CNT_W(CW)) u0 (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_done(cpu_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_baddr(mem_baddr), .mem_wblock(mem_wblock),
        .mem_rblock(mem_rblock), .mem_ready(mem_ready),
        .hit_count(hit_count), .miss_count(miss_count)
    );

    // Backing memory: answers each request after LAT waiting cycles.
    initial begin
        int wait_cnt;
        wait_cnt = 0;
        forever begin
            @(negedge clk);
            mem_ready = 1'b0;
            if (mem_req && !rst) begin
                if (wait_cnt == LAT) begin
                    if (mem_we) begin
                        mem_model[2*mem_baddr]     = mem_wblock[7:0];
                        mem_model[2*mem_baddr + 1] = mem_wblock[15:8];
                        wr_ops++;
                        last_wr_baddr = int'(mem_baddr);
                    end else begin
                        mem_rblock = {mem_model[2*mem_baddr + 1], mem_model[2*mem_baddr]};
                        rd_ops++;
                        last_rd_baddr = int'(mem_baddr);
                    end
                    mem_ready = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end else begin
                wait_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One access; called and returns at a falling edge.
    task automatic access(input bit we, input logic [3:0] addr, input logic [7:0] wd,
                          output int rd, output int lat, output int nw, output int nr);
        int w0, r0;
        w0 = wr_ops; r0 = rd_ops;
        cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!cpu_done && lat < 200);
        rd = int'(cpu_rdata);
        nw = wr_ops - w0;
        nr = rd_ops - r0;
        cpu_req = 1'b0; cpu_we = 1'b0;
        @(negedge clk);
        chk("R9 done single cycle", int'(cpu_done), 0);
    endtask

    task automatic t_reset;
        chk("R2 hit_count", int'(hit_count), 0);
        chk("R2 miss_count", int'(miss_count), 0);
        chk("R2 cpu_done", int'(cpu_done), 0);
        chk("R2 mem_req", int'(mem_req), 0);
    endtask

    task automatic t_walk_first;
        int rd, lat, nw, nr;
        access(0, 4'd1, 8'd0, rd, lat, nw, nr);
        chk("R5 load1 data", rd, 29);
        chk("R5 load1 reads", nr, 1);
        chk("R5 load1 writes", nw, 0);
        chk("R1 load1 block addr", last_rd_baddr, 0);
        access(0, 4'd8, 8'd0, rd, lat, nw, nr);
        chk("R8 load8 data", rd, 18);
        chk("R8 load8 clean eviction writes", nw, 0);
        access(1, 4'd4, 8'd18, rd, lat, nw, nr);
        chk("R7 store4 miss reads", nr, 1);
        chk("R7 store4 miss writes", nw, 0);
        chk("R1 store4 block addr", last_rd_baddr, 2);
        access(1, 4'd13, 8'd29, rd, lat, nw, nr);
        chk("R6 store13 writes", nw, 1);
        chk("R6 store13 reads", nr, 1);
        chk("R6 victim block addr", last_wr_baddr, 2);
        chk("R10 mem4 after eviction", int'(mem_model[4]), 18);
        chk("R7 mem5 untouched byte", int'(mem_model[5]), 150);
        access(0, 4'd9, 8'd0, rd, lat, nw, nr);
        chk("R3 load9 hit data", rd, 21);
        chk("R3 hit latency", lat, 1);
        chk("R3 hit no traffic", nw + nr, 0);
        chk("R10 hits after five", int'(hit_count), 1);
        chk("R10 misses after five", int'(miss_count), 4);
    endtask

    task automatic t_walk_second;
        int rd, lat, nw, nr;
        access(0, 4'd3, 8'd0, rd, lat, nw, nr);
        chk("R5 load3 data", rd, 123);
        chk("R5 load3 writes", nw, 0);
        access(1, 4'd2, 8'd29, rd, lat, nw, nr);
        chk("R4 store2 hit traffic", nw + nr, 0);
        chk("R4 store2 hit latency", lat, 1);
        access(0, 4'd11, 8'd0, rd, lat, nw, nr);
        chk("R6 load miss causes write", nw, 1);
        chk("R6 load11 data", rd, 28);
        chk("R1 load11 victim block addr", last_wr_baddr, 1);
        chk("R1 load11 fill block addr", last_rd_baddr, 5);
        chk("R10 mem2 written back", int'(mem_model[2]), 29);
        chk("R10 hits after eight", int'(hit_count), 2);
        chk("R10 misses after eight", int'(miss_count), 6);
    endtask

    task automatic t_store_burst;
        int rd, lat, nw, nr, sum;
        sum = 0;
        access(1, 4'd10, 8'd7, rd, lat, nw, nr); sum += nw + nr;
        access(1, 4'd11, 8'd8, rd, lat, nw, nr); sum += nw + nr;
        access(1, 4'd10, 8'd9, rd, lat, nw, nr); sum += nw + nr;
        chk("R4 store burst traffic", sum, 0);
        chk("R4 mem10 unchanged before eviction", int'(mem_model[10]), 33);
        access(0, 4'd2, 8'd0, rd, lat, nw, nr);
        chk("R6 burst eviction writes", nw, 1);
        chk("R4 mem10 after eviction", int'(mem_model[10]), 9);
        chk("R4 mem11 after eviction", int'(mem_model[11]), 8);
        chk("R6 load2 data", rd, 29);
    endtask

    task automatic t_clean_and_offset;
        int rd, lat, nw, nr;
        access(0, 4'd0, 8'd0, rd, lat, nw, nr);
        chk("R8 clean line evicted without write", nw, 0);
        chk("R8 load0 data", rd, 78);
        access(0, 4'd1, 8'd0, rd, lat, nw, nr);
        chk("R1 same block other offset hits", nr, 0);
        chk("R1 offset1 data", rd, 29);
        chk("R3 final hits", int'(hit_count), 6);
        chk("R5 final misses", int'(miss_count), 8);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            mem_model[i] = 8'd0;
        end
        mem_model[0] = 78;  mem_model[1] = 29;  mem_model[2] = 120; mem_model[3] = 123;
        mem_model[4] = 71;  mem_model[5] = 150; mem_model[6] = 162; mem_model[7] = 173;
        mem_model[8] = 18;  mem_model[9] = 21;  mem_model[10] = 33; mem_model[11] = 28;
        mem_model[12] = 19; mem_model[13] = 200; mem_model[14] = 210; mem_model[15] = 225;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        t_walk_first;
        t_walk_second;
        t_store_burst;
        t_clean_and_offset;
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule